// File: doc/BRIEF.md
# DMA Request Routing Channel

This block is one output lane of a DMA request router. A 127-line request bus carries requests from peripherals and request generators. A 7-bit selector picks one of those lines and hands it to a single DMA stream. In direct mode the chosen line reaches the stream with no delay. In synchronized mode the chosen line is held back until a chosen edge appears on one of several external interrupt lines. Each such edge then lets a programmed number of accepted requests through.

An internal down-counter tracks the accepted requests. When event generation is on, the counter reaching zero produces a one-cycle event pulse. In direct mode this happens once every programmed number of acceptances. A sticky overrun flag records any sync edge that arrives while the counter still holds a count. Software clears the flag with a write-one-to-clear bit in the same configuration word.

Top module: `dma_req_route_ch`

## Requirements
- R1: `cfg_wdata_i[6:0]` holds the selector. A value k in 1..127 routes bus bit k-1, because bus bit i carries request i+1. A value of 0 keeps `req_o` low whatever the bus holds.
- R2: With the sync-enable bit `cfg_wdata_i[7]` clear, `req_o` equals the selected request in the same cycle.
- R3: Sync input `sync_bus_i[s]` is chosen by `cfg_wdata_i[13:11]`. It passes through two flops before edge detection. The gate opens after the third rising clock edge that follows a valid input change, and is still closed after the second.
- R4: With sync enabled, a valid edge loads the counter with `cfg_wdata_i[18:14]` + 1. Each acceptance (`req_o` && `ack_i`) decrements the counter. `req_o` stays low while the counter is zero. Reset and every configuration write set the counter to zero.
- R5: The edge-polarity field `cfg_wdata_i[10:9]` is decoded as 00 = none, 01 = rising, 10 = falling, 11 = both. Edges on sync inputs that are not selected, and edges of the wrong polarity, leave the gate closed.
- R6: With `cfg_wdata_i[8]` set, `evt_o` is high for the one cycle after the acceptance that brings the count to zero. In direct mode this happens once every count+1 acceptances. With `cfg_wdata_i[8]` clear, `evt_o` never goes high.
- R7: A valid edge in sync mode while the count is nonzero sets `ovr_o` and reloads the counter. The flag stays set until a write with `cfg_wdata_i[19]` = 1. An edge while the count is zero does not set it.
- R8: After reset, `req_o`, `evt_o` and `ovr_o` are low and the selector is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 20 | Configuration word; bit 19 clears overrun |
| req_bus_i | input | 127 | Request lines; bit i is request i+1 |
| sync_bus_i | input | 8 | Asynchronous sync lines |
| ack_i | input | 1 | Stream accepts the current request |
| req_o | output | 1 | Routed request |
| evt_o | output | 1 | One-cycle count-done pulse |
| ovr_o | output | 1 | Sticky sync overrun flag |

## Verification
The bench sweeps every selector value against a one-hot bus and its complement. An off-by-one in the index would route a neighbour's request, and index 0 would leak bit 0 or bit 127. Every sync select and polarity is paired with a rising and a falling edge on both the watched line and another line. A decode that swaps rising and falling, or that listens to the wrong line, opens the gate when it should stay closed. Counts 0 to 7 and a direct-mode event cadence expose a counter that reloads with the field value instead of field+1, or that pulses the event one acceptance early or late. The overrun cases separate an edge that arrives mid-count from one that arrives at zero, and show whether the flag clears on the write-one bit.

// File: rtl/dma_route_pkg.sv
package dma_route_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_pol_e;
endpackage

// File: rtl/req_select.sv
module req_select #(
  parameter int NUM_REQ = 127,
  parameter int SEL_W   = 7
) (
  input  logic [NUM_REQ-1:0] req_bus_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               req_o
);
  localparam int NPAD = 2 ** SEL_W;

  logic [NPAD-1:0] pad;

  // slot 0 and slots past NUM_REQ read as idle
  always_comb begin
    pad = '0;
    pad[NUM_REQ:1] = req_bus_i;
  end

  assign req_o = pad[sel_i];
endmodule

// File: rtl/sync_edge_det.sv
module sync_edge_det
  import dma_route_pkg::*;
#(
  parameter int NUM_SYNC = 8,
  parameter int SEL_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SYNC-1:0] sync_bus_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  edge_pol_e           pol_i,
  output logic                edge_o
);
  localparam int NPAD = 2 ** SEL_W;

  logic [NPAD-1:0] rise, fall;

  for (genvar g = 0; g < NPAD; g++) begin : g_line
    if (g < NUM_SYNC) begin : g_live
      logic meta_q, sync_q, prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          meta_q <= 1'b0;
          sync_q <= 1'b0;
          prev_q <= 1'b0;
        end else begin
          meta_q <= sync_bus_i[g];
          sync_q <= meta_q;
          prev_q <= sync_q;
        end
      end
      assign rise[g] = sync_q & ~prev_q;
      assign fall[g] = ~sync_q & prev_q;
    end else begin : g_dead
      assign rise[g] = 1'b0;
      assign fall[g] = 1'b0;
    end
  end

  logic sel_rise, sel_fall;
  assign sel_rise = rise[sel_i];
  assign sel_fall = fall[sel_i];

  always_comb begin
    unique case (pol_i)
      EDGE_RISE: edge_o = sel_rise;
      EDGE_FALL: edge_o = sel_fall;
      EDGE_BOTH: edge_o = sel_rise | sel_fall;
      default:   edge_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/req_gate_cnt.sv
module req_gate_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic             ovr_clr_i,
  input  logic             sync_en_i,
  input  logic             evt_en_i,
  input  logic [CNT_W-1:0] cnt_field_i,
  input  logic             sel_req_i,
  input  logic             edge_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic             evt_o,
  output logic             ovr_o,
  output logic             cnt_zero_o
);
  localparam int RW = CNT_W + 1;

  logic [RW-1:0] cnt_q, load_val, base, rem;
  logic          gate, fire, reload, ovr_set;

  assign load_val   = {1'b0, cnt_field_i} + RW'(1);
  assign cnt_zero_o = (cnt_q == '0);
  assign gate       = !sync_en_i || !cnt_zero_o;
  assign req_o      = sel_req_i && gate;
  assign fire       = req_o && ack_i;
  // direct mode treats zero as a fresh period
  assign base       = cnt_zero_o ? load_val : cnt_q;
  assign rem        = base - RW'(1);
  assign reload     = sync_en_i && edge_i;
  assign ovr_set    = reload && !cnt_zero_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      evt_o <= 1'b0;
    end else begin
      evt_o <= evt_en_i && fire && (rem == '0) && !reload && !cfg_wr_i;
      if (cfg_wr_i)    cnt_q <= '0;
      else if (reload) cnt_q <= load_val;
      else if (fire)   cnt_q <= rem;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_o <= 1'b0;
    else if (ovr_set)   ovr_o <= 1'b1;
    else if (ovr_clr_i) ovr_o <= 1'b0;
  end
endmodule

// File: rtl/dma_req_route_ch.sv
module dma_req_route_ch
  import dma_route_pkg::*;
#(
  parameter int NUM_REQ  = 127,
  parameter int NUM_SYNC = 8,
  parameter int CNT_W    = 5,
  localparam int REQ_SEL_W = $clog2(NUM_REQ + 1),
  localparam int SYN_SEL_W = $clog2(NUM_SYNC),
  localparam int CFG_W     = REQ_SEL_W + 4 + SYN_SEL_W + CNT_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  input  logic [NUM_REQ-1:0]  req_bus_i,
  input  logic [NUM_SYNC-1:0] sync_bus_i,
  input  logic                ack_i,
  output logic                req_o,
  output logic                evt_o,
  output logic                ovr_o
);
  localparam int SYNC_EN_B = REQ_SEL_W;
  localparam int EVT_EN_B  = SYNC_EN_B + 1;
  localparam int POL_LSB   = EVT_EN_B + 1;
  localparam int SSEL_LSB  = POL_LSB + 2;
  localparam int CNT_LSB   = SSEL_LSB + SYN_SEL_W;
  localparam int CLR_B     = CNT_LSB + CNT_W;

  logic [CLR_B-1:0]     cfg_q;
  logic [REQ_SEL_W-1:0] reqsel_q;
  logic                 sync_en_q, evt_en_q;
  edge_pol_e            pol_q;
  logic [SYN_SEL_W-1:0] syncsel_q;
  logic [CNT_W-1:0]     cnt_field_q;
  logic                 sel_req, edge_hit, cnt_zero, ovr_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_wdata_i[CLR_B-1:0];
  end

  assign reqsel_q    = cfg_q[REQ_SEL_W-1:0];
  assign sync_en_q   = cfg_q[SYNC_EN_B];
  assign evt_en_q    = cfg_q[EVT_EN_B];
  assign pol_q       = edge_pol_e'(cfg_q[POL_LSB +: 2]);
  assign syncsel_q   = cfg_q[SSEL_LSB +: SYN_SEL_W];
  assign cnt_field_q = cfg_q[CNT_LSB +: CNT_W];
  assign ovr_clr     = cfg_we_i && cfg_wdata_i[CLR_B];

  req_select #(.NUM_REQ(NUM_REQ), .SEL_W(REQ_SEL_W)) u_sel (
    .req_bus_i (req_bus_i),
    .sel_i     (reqsel_q),
    .req_o     (sel_req)
  );

  sync_edge_det #(.NUM_SYNC(NUM_SYNC), .SEL_W(SYN_SEL_W)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_bus_i (sync_bus_i),
    .sel_i      (syncsel_q),
    .pol_i      (pol_q),
    .edge_o     (edge_hit)
  );

  req_gate_cnt #(.CNT_W(CNT_W)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_wr_i    (cfg_we_i),
    .ovr_clr_i   (ovr_clr),
    .sync_en_i   (sync_en_q),
    .evt_en_i    (evt_en_q),
    .cnt_field_i (cnt_field_q),
    .sel_req_i   (sel_req),
    .edge_i      (edge_hit),
    .ack_i       (ack_i),
    .req_o       (req_o),
    .evt_o       (evt_o),
    .ovr_o       (ovr_o),
    .cnt_zero_o  (cnt_zero)
  );
endmodule

// File: rtl/dma_req_route_ch_chk.sv
module dma_req_route_ch_chk #(
  parameter int NUM_REQ = 127,
  parameter int SEL_W   = 7,
  parameter int CFG_W   = 20
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_we_i,
  input logic [CFG_W-1:0]   cfg_wdata_i,
  input logic [NUM_REQ-1:0] req_bus_i,
  input logic               ack_i,
  input logic               req_o,
  input logic               evt_o,
  input logic               ovr_o,
  input logic [SEL_W-1:0]   reqsel_q,
  input logic               sync_en_q,
  input logic               cnt_zero
);
  logic [2**SEL_W-1:0] pad;
  always_comb begin
    pad = '0;
    pad[NUM_REQ:1] = req_bus_i;
  end

  AST_IDX0_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reqsel_q == '0) |-> !req_o); // R1
  AST_FWD_FROM_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> pad[reqsel_q]); // R1
  AST_DIRECT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_en_q |-> (req_o == pad[reqsel_q])); // R2
  AST_GATE_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_en_q && cnt_zero) |-> !req_o); // R4
  AST_EVT_AFTER_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(req_o && ack_i)); // R6
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !(cfg_we_i && cfg_wdata_i[CFG_W-1])) |=> ovr_o); // R7
endmodule

bind dma_req_route_ch dma_req_route_ch_chk #(
  .NUM_REQ (NUM_REQ),
  .SEL_W   (REQ_SEL_W),
  .CFG_W   (CFG_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .req_bus_i   (req_bus_i),
  .ack_i       (ack_i),
  .req_o       (req_o),
  .evt_o       (evt_o),
  .ovr_o       (ovr_o),
  .reqsel_q    (reqsel_q),
  .sync_en_q   (sync_en_q),
  .cnt_zero    (cnt_zero)
);

// File: tb/dma_req_route_ch_tb_top.sv
module dma_req_route_ch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ  = 127;
  localparam int NSYNC = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cfg_we_i = 1'b0;
  logic [19:0]       cfg_wdata_i = '0;
  logic [NREQ-1:0]   req_bus_i = '0;
  logic [NSYNC-1:0]  sync_bus_i = '0;
  logic              ack_i = 1'b0;
  logic              req_o, evt_o, ovr_o;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_req_route_ch dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .req_bus_i   (req_bus_i),
    .sync_bus_i  (sync_bus_i),
    .ack_i       (ack_i),
    .req_o       (req_o),
    .evt_o       (evt_o),
    .ovr_o       (ovr_o)
  );

  function automatic logic [19:0] mk(int rs, bit se, bit ee, int pol, int ss, int cnt, bit clr);
    return {clr, 5'(cnt), 3'(ss), 2'(pol), ee, se, 7'(rs)};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic wr(logic [19:0] w);
    cfg_we_i = 1'b1;
    cfg_wdata_i = w;
    tick();
    cfg_we_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int fires, evts;
    tick(3);
    rst_ni = 1'b1;
    tick();
    #1;
    chk("R8 req", int'(req_o), 0);
    chk("R8 evt", int'(evt_o), 0);
    chk("R8 ovr", int'(ovr_o), 0);
    req_bus_i = '1;
    #1 chk("R8 sel0 after reset", int'(req_o), 0);

    // R1/R2 selector sweep, direct mode
    for (int k = 0; k < 128; k++) begin
      wr(mk(k, 0, 0, 0, 0, 0, 0));
      req_bus_i = '0;
      if (k != 0) req_bus_i[k-1] = 1'b1;
      #1 chk("R1 onehot", int'(req_o), (k != 0) ? 1 : 0);
      req_bus_i = ~req_bus_i;
      #1 chk("R2 complement", int'(req_o), (k == 0) ? 0 : 0);
      if (k != 0) begin
        req_bus_i[k-1] = 1'b1;
        #1 chk("R2 same cycle", int'(req_o), 1);
      end
    end

    // R3 latency boundary
    req_bus_i = '0;
    req_bus_i[8] = 1'b1;
    wr(mk(9, 1, 0, 1, 2, 3, 0));
    #1 chk("R4 closed after write", int'(req_o), 0);
    sync_bus_i[2] = 1'b1;
    tick(2);
    #1 chk("R3 closed at 2", int'(req_o), 0);
    tick();
    #1 chk("R3 open at 3", int'(req_o), 1);
    sync_bus_i = '0;
    tick(4);

    // R3/R5 sync select and polarity sweep
    for (int s = 0; s < NSYNC; s++) begin
      for (int p = 0; p < 4; p++) begin
        for (int t = 0; t < 2; t++) begin
          int j;
          j = (t == 0) ? s : (s + 3) % NSYNC;
          wr(mk(9, 1, 0, p, s, 0, 0));
          sync_bus_i[j] = 1'b1;
          tick(3);
          #1 chk("R5 rise", int'(req_o), (j == s && (p == 1 || p == 3)) ? 1 : 0);
          ack_i = 1'b1;
          tick();
          ack_i = 1'b0;
          sync_bus_i[j] = 1'b0;
          tick(3);
          #1 chk("R5 fall", int'(req_o), (j == s && (p == 2 || p == 3)) ? 1 : 0);
          ack_i = 1'b1;
          tick();
          ack_i = 1'b0;
        end
      end
    end

    // R4/R6 count sweep in sync mode
    req_bus_i = '0;
    req_bus_i[0] = 1'b1;
    for (int n = 0; n < 8; n++) begin
      for (int e = 0; e < 2; e++) begin
        sync_bus_i = '0;
        tick(3);
        wr(mk(1, 1, e[0], 1, 0, n, 0));
        ack_i = 1'b1;
        sync_bus_i[0] = 1'b1;
        fires = 0;
        evts = 0;
        for (int c = 0; c < 20; c++) begin
          #1;
          if (req_o) fires++;
          if (evt_o) evts++;
          tick();
        end
        ack_i = 1'b0;
        chk("R4 accepted per edge", fires, n + 1);
        chk("R6 events per edge", evts, e);
      end
    end
    #1 chk("R7 no overrun on drained edges", int'(ovr_o), 0);

    // R6 direct-mode cadence
    for (int e = 0; e < 2; e++) begin
      wr(mk(1, 0, e[0], 0, 0, 2, 0));
      ack_i = 1'b1;
      for (int i = 1; i <= 9; i++) begin
        tick();
        #1 chk("R6 direct cadence", int'(evt_o), (e == 1 && i % 3 == 0) ? 1 : 0);
      end
      ack_i = 1'b0;
    end

    // R7 overrun
    sync_bus_i = '0;
    req_bus_i = '0;
    req_bus_i[2] = 1'b1;
    tick(3);
    wr(mk(3, 1, 0, 3, 5, 10, 0));
    sync_bus_i[5] = 1'b1;
    tick(4);
    #1 chk("R7 no overrun first edge", int'(ovr_o), 0);
    chk("R4 open after edge", int'(req_o), 1);
    sync_bus_i[5] = 1'b0;
    tick(3);
    #1 chk("R7 overrun mid count", int'(ovr_o), 1);
    tick(3);
    #1 chk("R7 overrun held", int'(ovr_o), 1);
    wr(mk(3, 1, 0, 3, 5, 0, 0));
    #1 chk("R7 held without clear bit", int'(ovr_o), 1);
    wr(mk(3, 1, 0, 3, 5, 0, 1));
    #1 chk("R7 cleared", int'(ovr_o), 0);
    ack_i = 1'b1;
    sync_bus_i[5] = 1'b1;
    tick(5);
    sync_bus_i[5] = 1'b0;
    tick(5);
    #1 chk("R7 edge at zero no overrun", int'(ovr_o), 0);
    ack_i = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule